// File: doc/BRIEF.md
# Mode-banked processor register file

This block holds the architectural register state of a small processor core. It presents sixteen architectural registers and a current status word. Index 13 serves as the stack pointer, index 14 as the link register and index 15 as the program counter. Behind the sixteen indices sit thirty-one physical registers. The current operating mode decides which physical copy each index reaches. Fast-interrupt mode has private copies of indices 8 to 14. The interrupt, supervisor, abort and undefined modes each have private copies of indices 13 and 14 only. Every mode other than user and system also owns a saved status register.

The core reads through two combinational ports and writes through one clocked port, each addressed by a 4-bit index. Two further strobes serve control flow. A link strobe copies the aligned program counter into index 14 of the active mode. An exception-entry strobe does two things: it stores a supplied return address into index 14 of the mode being entered, and it stores the status word in effect into that mode's saved status register. The program counter is read back aligned to the instruction-set state.

Top module: `bankRegFile`

## Requirements
- R1: After an asynchronous active-low reset, every physical register, every saved status register and the status word read as zero.
- R2: In user mode (10000) and system mode (11111), all sixteen indices reach the shared user copies. A write through the write port is visible on both read ports after the next rising edge, and reads are combinational.
- R3: In fast-interrupt mode (10001), indices 8 to 14 reach seven private copies, and writes to them leave the user copies unchanged. Indices 0 to 7 and 15 stay shared.
- R4: In interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes, indices 13 and 14 reach copies private to that mode, while indices 0 to 12 and 15 reach the user copies.
- R5: Changing the mode input never changes any stored value. Returning to a mode shows the values it held before.
- R6: A link strobe writes the aligned program counter, as it reads before the edge, into index 14 of the current mode. When the write port targets the same physical register in the same cycle, the link value wins.
- R7: An exception-entry strobe with a target mode that owns a saved status register does two things at the edge. It writes the supplied return address into that mode's index 14, and it writes the pre-edge status word into that mode's saved status register. It overrides an ordinary write, a link write or a saved-status write aimed at the same physical register in that cycle. A target of user, system or an unknown code has no effect.
- R8: Reads of index 15, and the pcOut port, return the program counter aligned by isaState. 00 (32-bit state) clears bits 1:0, 01 (16-bit state) clears bit 0, 10 (byte-code state) leaves it unaligned, and 11 is treated like 00.
- R9: In a mode without a saved status register, spsrRdData reads zero and a saved-status write is ignored. spsrErr is high combinationally in any cycle where spsrRdEn or spsrWrEn is asserted in such a mode, and it is low otherwise.
- R10: A mode code outside the seven listed encodings behaves like user mode: it uses the user copies and has no saved status register.
- R11: statusWrEn loads statusWrData into the status word at the rising edge, and statusOut shows it from then on. In a mode that owns one, spsrWrEn loads spsrWrData into that mode's saved status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| curMode | input | 5 | Current operating mode code |
| isaState | input | 2 | Instruction-set state used for program counter alignment |
| rdIdxA | input | 4 | Read port A architectural index |
| rdDataA | output | DATA_W | Read port A data |
| rdIdxB | input | 4 | Read port B architectural index |
| rdDataB | output | DATA_W | Read port B data |
| wrEn | input | 1 | Write port enable |
| wrIdx | input | 4 | Write port architectural index |
| wrData | input | DATA_W | Write port data |
| linkWr | input | 1 | Branch-with-link strobe |
| excEntry | input | 1 | Exception-entry strobe |
| excMode | input | 5 | Mode being entered on exception |
| excRetPc | input | DATA_W | Return address saved on exception entry |
| statusWrEn | input | 1 | Status word write enable |
| statusWrData | input | DATA_W | Status word write data |
| statusOut | output | DATA_W | Current status word |
| spsrRdEn | input | 1 | Saved status access strobe (read) |
| spsrWrEn | input | 1 | Saved status write enable |
| spsrWrData | input | DATA_W | Saved status write data |
| spsrRdData | output | DATA_W | Saved status register of the current mode, zero if none |
| spsrErr | output | 1 | Saved status access in a mode lacking one |
| pcOut | output | DATA_W | Aligned program counter |

## Verification
Read data, pcOut, spsrRdData and spsrErr are combinational, so they respond in the same cycle as a change of index, mode or isaState. Every write source (write port, link, exception entry, status and saved-status writes) lands at the next rising edge and shows in the following cycle. The bench applies inputs just after a falling edge and compares all outputs against a behavioural model shortly afterwards, before the rising edge. It then advances the model at that rising edge using the same inputs. The model therefore predicts exactly one edge of latency for state and none for reads.

// File: rtl/rfPkg.sv
package rfPkg;
  localparam int ARCH_REGS   = 16;
  localparam int FIQ_BANKED  = 7;
  localparam int SMALL_BANKS = 4;
  localparam int SMALL_DEPTH = 2;
  localparam int PHYS_REGS   = ARCH_REGS + FIQ_BANKED + SMALL_BANKS * SMALL_DEPTH;
  localparam int PHYS_W      = $clog2(PHYS_REGS);
  localparam int SPSR_NUM    = SMALL_BANKS + 1;
  localparam int SPSR_W      = $clog2(SPSR_NUM);
  localparam int PC_IDX      = 15;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } modeE;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bankE;

  typedef enum logic [1:0] {
    ISA_WORD = 2'd0,
    ISA_HALF = 2'd1,
    ISA_BYTE = 2'd2,
    ISA_RSVD = 2'd3
  } isaE;

  typedef struct packed {
    logic              wrEn;
    logic [PHYS_W-1:0] wrPhys;
    logic              linkEn;
    logic [PHYS_W-1:0] linkPhys;
    logic              excEn;
    logic [PHYS_W-1:0] excPhys;
    logic [SPSR_W-1:0] excSlot;
    logic              spsrWrEn;
    logic [SPSR_W-1:0] curSlot;
    logic              curHasSaved;
  } rfStrobeS;

  function automatic bankE modeToBank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return BANK_FIQ;
      MODE_IRQ: return BANK_IRQ;
      MODE_SVC: return BANK_SVC;
      MODE_ABT: return BANK_ABT;
      MODE_UND: return BANK_UND;
      default:  return BANK_USR;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] physOf(input bankE b, input logic [3:0] idx);
    int p;
    p = int'(idx);
    if (b == BANK_FIQ && idx >= 4'd8 && idx <= 4'd14)
      p = ARCH_REGS + int'(idx) - 8;
    else if (b != BANK_USR && b != BANK_FIQ && idx >= 4'd13 && idx <= 4'd14)
      p = ARCH_REGS + FIQ_BANKED + SMALL_DEPTH * (int'(b) - int'(BANK_IRQ)) + int'(idx) - 13;
    return PHYS_W'(p);
  endfunction

  function automatic logic [SPSR_W-1:0] slotOf(input bankE b);
    if (b == BANK_USR) return '0;
    return SPSR_W'(int'(b) - int'(BANK_FIQ));
  endfunction
endpackage

// File: rtl/rfCtrl.sv
module rfCtrl
  import rfPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        curMode,
  input  logic [4:0]        excMode,
  input  logic [3:0]        rdIdxA,
  input  logic [3:0]        rdIdxB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic              linkWr,
  input  logic              excEntry,
  input  logic              spsrRdEn,
  input  logic              spsrWrEn,
  output logic [PHYS_W-1:0] rdPhysA,
  output logic [PHYS_W-1:0] rdPhysB,
  output rfStrobeS          strobes,
  output logic              spsrErr
);
  bankE curBank;
  bankE excBank;
  logic curSaved;
  logic excSaved;

  always_comb begin
    curBank  = modeToBank(curMode);
    excBank  = modeToBank(excMode);
    curSaved = (curBank != BANK_USR);
    excSaved = (excBank != BANK_USR);
  end

  always_comb begin
    rdPhysA = physOf(curBank, rdIdxA);
    rdPhysB = physOf(curBank, rdIdxB);

    strobes             = '0;
    strobes.wrEn        = wrEn;
    strobes.wrPhys      = physOf(curBank, wrIdx);
    strobes.linkEn      = linkWr;
    strobes.linkPhys    = physOf(curBank, 4'd14);
    strobes.excEn       = excEntry && excSaved;
    strobes.excPhys     = physOf(excBank, 4'd14);
    strobes.excSlot     = slotOf(excBank);
    strobes.spsrWrEn    = spsrWrEn && curSaved;
    strobes.curSlot     = slotOf(curBank);
    strobes.curHasSaved = curSaved;

    spsrErr = (spsrRdEn || spsrWrEn) && !curSaved;
  end

  // R3: fast-interrupt indices 8..14 never land on user copies
  p_fiq_private_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_FIQ && rdIdxA >= 4'd8 && rdIdxA <= 4'd14)
      |-> (rdPhysA >= PHYS_W'(ARCH_REGS) && rdPhysA < PHYS_W'(ARCH_REGS + FIQ_BANKED)));

  // R4: low indices are shared in every mode
  p_low_shared_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdIdxB < 4'd8) |-> (rdPhysB == PHYS_W'(rdIdxB)));

  // R9: an erroneous access never produces a saved-status write
  p_err_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    spsrErr |-> !strobes.spsrWrEn);

  // R7: exception strobe into user/system mode is dropped
  p_exc_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (excMode == MODE_USR || excMode == MODE_SYS) |-> !strobes.excEn);
endmodule

// File: rtl/rfDatapath.sv
module rfDatapath
  import rfPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobeS          strobes,
  input  logic [PHYS_W-1:0] rdPhysA,
  input  logic [PHYS_W-1:0] rdPhysB,
  input  logic [3:0]        rdIdxA,
  input  logic [3:0]        rdIdxB,
  input  logic [1:0]        isaState,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] excRetPc,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] spsrRdData
);
  logic [DATA_W-1:0] physRegs [PHYS_REGS];
  logic [DATA_W-1:0] spsrRegs [SPSR_NUM];
  logic [DATA_W-1:0] statusReg;
  logic [DATA_W-1:0] pcAligned;
  logic [DATA_W-1:0] pcRaw;

  assign pcRaw = physRegs[PC_IDX];

  always_comb begin
    case (isaE'(isaState))
      ISA_HALF: pcAligned = {pcRaw[DATA_W-1:1], 1'b0};
      ISA_BYTE: pcAligned = pcRaw;
      default:  pcAligned = {pcRaw[DATA_W-1:2], 2'b00};
    endcase
  end

  always_comb begin
    rdDataA    = (rdIdxA == 4'(PC_IDX)) ? pcAligned : physRegs[rdPhysA];
    rdDataB    = (rdIdxB == 4'(PC_IDX)) ? pcAligned : physRegs[rdPhysB];
    pcOut      = pcAligned;
    statusOut  = statusReg;
    spsrRdData = strobes.curHasSaved ? spsrRegs[strobes.curSlot] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PHYS_REGS; i++) physRegs[i] <= '0;
    end else begin
      for (int i = 0; i < PHYS_REGS; i++) begin
        if (strobes.excEn && strobes.excPhys == PHYS_W'(i))
          physRegs[i] <= excRetPc;
        else if (strobes.linkEn && strobes.linkPhys == PHYS_W'(i))
          physRegs[i] <= pcAligned;
        else if (strobes.wrEn && strobes.wrPhys == PHYS_W'(i))
          physRegs[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int j = 0; j < SPSR_NUM; j++) spsrRegs[j] <= '0;
    end else begin
      for (int j = 0; j < SPSR_NUM; j++) begin
        if (strobes.excEn && strobes.excSlot == SPSR_W'(j))
          spsrRegs[j] <= statusReg;
        else if (strobes.spsrWrEn && strobes.curSlot == SPSR_W'(j))
          spsrRegs[j] <= spsrWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           statusReg <= '0;
    else if (statusWrEn) statusReg <= statusWrData;
  end

  // R5: an untargeted physical register holds its value
  for (genvar g = 0; g < PHYS_REGS; g++) begin : gHold
    p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!(strobes.wrEn   && strobes.wrPhys   == PHYS_W'(g)) &&
       !(strobes.linkEn && strobes.linkPhys == PHYS_W'(g)) &&
       !(strobes.excEn  && strobes.excPhys  == PHYS_W'(g)))
        |=> $stable(physRegs[g]));
  end

  // R6: link write lands the aligned program counter
  p_link_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.linkEn && !(strobes.excEn && strobes.excPhys == strobes.linkPhys))
      |=> physRegs[$past(strobes.linkPhys)] == $past(pcAligned));

  // R7: exception entry saves return address and prior status
  p_exc_save_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.excEn |=> (physRegs[$past(strobes.excPhys)] == $past(excRetPc) &&
                       spsrRegs[$past(strobes.excSlot)] == $past(statusReg)));

  // R8: aligned outputs respect the instruction-set state
  p_pc_align_r8: assert property (@(posedge clk) disable iff (!rstN)
    (isaState != 2'(ISA_BYTE)) |-> (pcOut[0] == 1'b0));
endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import rfPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        curMode,
  input  logic [1:0]        isaState,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              linkWr,
  input  logic              excEntry,
  input  logic [4:0]        excMode,
  input  logic [DATA_W-1:0] excRetPc,
  input  logic              statusWrEn,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] statusOut,
  input  logic              spsrRdEn,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrRdData,
  output logic              spsrErr,
  output logic [DATA_W-1:0] pcOut
);
  rfStrobeS          strobes;
  logic [PHYS_W-1:0] rdPhysA;
  logic [PHYS_W-1:0] rdPhysB;

  rfCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .curMode  (curMode),
    .excMode  (excMode),
    .rdIdxA   (rdIdxA),
    .rdIdxB   (rdIdxB),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .linkWr   (linkWr),
    .excEntry (excEntry),
    .spsrRdEn (spsrRdEn),
    .spsrWrEn (spsrWrEn),
    .rdPhysA  (rdPhysA),
    .rdPhysB  (rdPhysB),
    .strobes  (strobes),
    .spsrErr  (spsrErr)
  );

  rfDatapath #(.DATA_W(DATA_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .rdPhysA      (rdPhysA),
    .rdPhysB      (rdPhysB),
    .rdIdxA       (rdIdxA),
    .rdIdxB       (rdIdxB),
    .isaState     (isaState),
    .wrData       (wrData),
    .excRetPc     (excRetPc),
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .spsrWrData   (spsrWrData),
    .rdDataA      (rdDataA),
    .rdDataB      (rdDataB),
    .pcOut        (pcOut),
    .statusOut    (statusOut),
    .spsrRdData   (spsrRdData)
  );

  // R9: a saved-status access error coincides with a zero read
  p_spsr_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    spsrErr |-> (spsrRdData == '0));
endmodule

// File: tb/tb_bankRegFile.sv
`timescale 1ns/1ps
module tb_bankRegFile;
  localparam int W = 32;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10100;

  logic clk = 0;
  logic rstN = 0;
  logic [4:0] curMode = USR, excMode = USR;
  logic [1:0] isaState = 2'd0;
  logic [3:0] rdIdxA = 0, rdIdxB = 0, wrIdx = 0;
  logic wrEn = 0, linkWr = 0, excEntry = 0, statusWrEn = 0, spsrRdEn = 0, spsrWrEn = 0;
  logic [W-1:0] wrData = 0, excRetPc = 0, statusWrData = 0, spsrWrData = 0;
  logic [W-1:0] rdDataA, rdDataB, statusOut, spsrRdData, pcOut;
  logic spsrErr;

  int nTests = 0;
  int nFails = 0;

  logic [W-1:0] mUsr [16];
  logic [W-1:0] mFiq [7];
  logic [W-1:0] mSm  [4][2];
  logic [W-1:0] mSpsr[5];
  logic [W-1:0] mStatus;

  always #4 clk = ~clk;

  bankRegFile #(.DATA_W(W)) dut (
    .clk(clk), .rstN(rstN), .curMode(curMode), .isaState(isaState),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .linkWr(linkWr),
    .excEntry(excEntry), .excMode(excMode), .excRetPc(excRetPc),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .statusOut(statusOut),
    .spsrRdEn(spsrRdEn), .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData),
    .spsrRdData(spsrRdData), .spsrErr(spsrErr), .pcOut(pcOut)
  );

  function automatic int smIdx(logic [4:0] m);
    if (m == IRQ) return 0;
    if (m == SVC) return 1;
    if (m == ABT) return 2;
    if (m == UND) return 3;
    return -1;
  endfunction

  function automatic int spIdx(logic [4:0] m);
    if (m == FIQ) return 0;
    return (smIdx(m) >= 0) ? smIdx(m) + 1 : -1;
  endfunction

  function automatic logic [W-1:0] alignPc(logic [W-1:0] pc, logic [1:0] st);
    if (st == 2'd1) return pc & ~32'h1;
    if (st == 2'd2) return pc;
    return pc & ~32'h3;
  endfunction

  function automatic logic [W-1:0] mRead(logic [4:0] m, int idx);
    if (idx == 15) return alignPc(mUsr[15], isaState);
    if (m == FIQ && idx >= 8 && idx <= 14) return mFiq[idx-8];
    if (smIdx(m) >= 0 && idx >= 13) return mSm[smIdx(m)][idx-13];
    return mUsr[idx];
  endfunction

  task automatic mWrite(logic [4:0] m, int idx, logic [W-1:0] v);
    if (m == FIQ && idx >= 8 && idx <= 14) mFiq[idx-8] = v;
    else if (smIdx(m) >= 0 && idx >= 13 && idx <= 14) mSm[smIdx(m)][idx-13] = v;
    else mUsr[idx] = v;
  endtask

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [W-1:0] expSpsr;
    logic expErr;
    expSpsr = (spIdx(curMode) >= 0) ? mSpsr[spIdx(curMode)] : '0;
    expErr  = (spsrRdEn || spsrWrEn) && (spIdx(curMode) < 0);
    chk(tag, "rdDataA", rdDataA, mRead(curMode, int'(rdIdxA)));
    chk(tag, "rdDataB", rdDataB, mRead(curMode, int'(rdIdxB)));
    chk(tag, "pcOut", pcOut, alignPc(mUsr[15], isaState));
    chk(tag, "statusOut", statusOut, mStatus);
    chk(tag, "spsrRdData", spsrRdData, expSpsr);
    chk(tag, "spsrErr", {31'b0, spsrErr}, {31'b0, expErr});
  endtask

  task automatic modelEdge();
    logic [W-1:0] oldPc, oldStatus;
    oldPc     = alignPc(mUsr[15], isaState);
    oldStatus = mStatus;
    if (wrEn) mWrite(curMode, int'(wrIdx), wrData);
    if (linkWr) mWrite(curMode, 14, oldPc);
    if (spsrWrEn && spIdx(curMode) >= 0) mSpsr[spIdx(curMode)] = spsrWrData;
    if (excEntry && spIdx(excMode) >= 0) begin
      mWrite(excMode, 14, excRetPc);
      mSpsr[spIdx(excMode)] = oldStatus;
    end
    if (statusWrEn) mStatus = statusWrData;
  endtask

  // Inputs are already set after a falling edge; compare, clock, update model.
  task automatic cycle(string tag);
    #1;
    checkAll(tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    wrEn = 0; linkWr = 0; excEntry = 0; statusWrEn = 0; spsrRdEn = 0; spsrWrEn = 0;
  endtask

  task automatic doWrite(string tag, logic [4:0] m, int idx, logic [W-1:0] v);
    curMode = m; wrEn = 1; wrIdx = 4'(idx); wrData = v;
    cycle(tag);
  endtask

  task automatic look(string tag, logic [4:0] m, int a, int b);
    curMode = m; rdIdxA = 4'(a); rdIdxB = 4'(b);
    cycle(tag);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mUsr[i] = '0;
    for (int i = 0; i < 7; i++) mFiq[i] = '0;
    for (int i = 0; i < 4; i++) begin mSm[i][0] = '0; mSm[i][1] = '0; end
    for (int i = 0; i < 5; i++) mSpsr[i] = '0;
    mStatus = '0;

    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset contents
    look("R1", USR, 0, 15);
    look("R1", FIQ, 8, 14);

    // R2: user-mode writes, read back in user and system
    for (int i = 0; i < 16; i++) doWrite("R2", USR, i, 32'h1000_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < 16; i++) look("R2", SYS, i, 15 - i);

    // R3: fast-interrupt private copies
    for (int i = 8; i < 15; i++) doWrite("R3", FIQ, i, 32'hF1F0_0000 + 32'(i));
    look("R3", FIQ, 8, 7);
    look("R3", USR, 8, 14);
    look("R3", FIQ, 14, 0);

    // R4: two private registers per remaining privileged mode
    doWrite("R4", IRQ, 13, 32'h1A1A_0013); doWrite("R4", IRQ, 14, 32'h1A1A_0014);
    doWrite("R4", SVC, 13, 32'h5C5C_0013); doWrite("R4", SVC, 14, 32'h5C5C_0014);
    doWrite("R4", ABT, 13, 32'hAB00_0013); doWrite("R4", ABT, 14, 32'hAB00_0014);
    doWrite("R4", UND, 13, 32'hDD00_0013); doWrite("R4", UND, 14, 32'hDD00_0014);
    doWrite("R4", SVC, 12, 32'h5C5C_0012);
    look("R4", USR, 12, 13);
    look("R4", IRQ, 12, 13);
    look("R4", ABT, 8, 14);

    // R5: mode hopping does not disturb contents
    look("R5", USR, 13, 14);
    look("R5", UND, 13, 14);
    look("R5", FIQ, 13, 9);
    look("R5", SVC, 14, 13);

    // R8: program counter alignment per state
    doWrite("R8", USR, 15, 32'h0000_1003);
    isaState = 2'd0; look("R8", USR, 15, 0);
    isaState = 2'd1; look("R8", USR, 15, 0);
    isaState = 2'd2; look("R8", FIQ, 15, 15);
    isaState = 2'd3; look("R8", USR, 15, 15);

    // R6: link write beats ordinary write to same register
    isaState = 2'd1;
    curMode = SVC; linkWr = 1; wrEn = 1; wrIdx = 4'd14; wrData = 32'hBAD0_BAD0;
    rdIdxA = 14; cycle("R6");
    look("R6", SVC, 14, 15);
    curMode = USR; linkWr = 1; cycle("R6");
    look("R6", USR, 14, 13);

    // R11: status word and saved status writes
    curMode = USR; statusWrEn = 1; statusWrData = 32'h0000_00A5; cycle("R11");
    curMode = ABT; spsrWrEn = 1; spsrWrData = 32'h0000_0077; cycle("R11");
    look("R11", ABT, 0, 0);

    // R7: exception entry beats ordinary and saved-status writes
    curMode = IRQ; excEntry = 1; excMode = IRQ; excRetPc = 32'h2222_2222;
    wrEn = 1; wrIdx = 4'd14; wrData = 32'h9999_9999;
    spsrWrEn = 1; spsrWrData = 32'h5555_5555;
    statusWrEn = 1; statusWrData = 32'h0000_00C3;
    cycle("R7");
    curMode = IRQ; spsrRdEn = 1; rdIdxA = 14; cycle("R7");
    curMode = USR; excEntry = 1; excMode = SVC; excRetPc = 32'h3333_0001; cycle("R7");
    look("R7", SVC, 14, 13);
    curMode = USR; excEntry = 1; excMode = SYS; excRetPc = 32'hDEAD_0000; cycle("R7");
    look("R7", USR, 14, 13);
    curMode = SYS; excEntry = 1; excMode = BAD; excRetPc = 32'hDEAD_0001; cycle("R7");
    look("R7", SYS, 14, 0);

    // R9: saved status absent in user/system
    curMode = USR; spsrRdEn = 1; cycle("R9");
    curMode = SYS; spsrWrEn = 1; spsrWrData = 32'hFFFF_FFFF; cycle("R9");
    look("R9", SYS, 0, 1);
    curMode = SVC; spsrRdEn = 1; cycle("R9");
    curMode = FIQ; spsrWrEn = 1; spsrWrData = 32'h0F0F_0F0F; cycle("R9");
    look("R9", FIQ, 8, 13);

    // R10: unknown mode code behaves as user
    look("R10", BAD, 13, 14);
    doWrite("R10", BAD, 8, 32'h0BAD_0008);
    look("R10", USR, 8, 9);
    curMode = BAD; spsrRdEn = 1; cycle("R10");

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule